// File: doc/BRIEF.md
# Parallel EPROM Read-Cycle Controller

This block sits on the host side of an asynchronous byte-wide one-time-programmable memory with a 19-bit address. It turns single-word read requests into chip-enable, output-enable and address waveforms that respect the memory's access delays. All of those delays are counted in system clock cycles. The host presents `req` with `addr` while `busy` is low. The controller drives the memory pins and samples the data byte once every access delay has run out. It returns the byte on `rdata` with a one-cycle `rvalid` strobe. It then keeps `busy` high until the memory's output driver has had time to float.

Each delay is a parameter in nanoseconds, together with the clock period. Each is turned into ceil(t / period) cycles, with a minimum of one. The address and chip-enable delays are both counted from the start of the access. Output-enable is asserted late, exactly the output-enable access time before the capture edge, so the memory drives the bus for the shortest possible time and no access time is lost. When idle, chip-enable is high (standby). If a request for the same address arrives in the single cycle after the float wait, chip-enable is kept low and only the output-enable delay is paid. A request for a different address in that cycle forces one cycle of standby first.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, mem_ce_n and mem_oe_n are high, busy is low and rvalid is low.
- R2: With default timing (20 ns clock; 90 ns address and chip-enable access; 50 ns output-enable access; 60 ns float), a request accepted from standby yields rvalid exactly 5 cycles after the accepting clock edge. The byte returned is the one on mem_data at the capture edge.
- R3: mem_oe_n is low only while mem_ce_n is low. It falls exactly the output-enable delay (3 cycles by default) before the capture edge.
- R4: From the acceptance of a request until its capture edge, mem_addr and mem_ce_n do not change.
- R5: rvalid is a single-cycle pulse. mem_oe_n is already high in the cycle that rvalid is high, because controls are released at the capture edge.
- R6: After the capture edge, busy stays high for exactly the float delay (3 cycles by default). mem_oe_n does not fall again until at least that many cycles after it rose.
- R7: A request for the same address in the first cycle busy is low again keeps mem_ce_n low. Its rvalid follows 3 cycles (the output-enable delay) after acceptance.
- R8: A request for a different address in that cycle raises mem_ce_n for one cycle with the new address already driven. Its rvalid follows 6 cycles (full delay plus one) after acceptance.
- R9: If no request arrives in that first non-busy cycle, mem_ce_n goes high at the next edge (standby).
- R10: A request while busy is high is ignored: no extra rvalid, and mem_addr keeps the address of the access in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, taken when busy is low |
| addr | input | 19 | Word address of the request |
| busy | output | 1 | High while an access or float wait is in progress |
| rdata | output | 8 | Captured data byte |
| rvalid | output | 1 | One-cycle strobe marking rdata as new |
| mem_addr | output | 19 | Address to the memory |
| mem_ce_n | output | 1 | Chip-enable to the memory, active low |
| mem_oe_n | output | 1 | Output-enable to the memory, active low |
| mem_data | input | 8 | Data bus from the memory |

## Verification
A wrong state or counter value shows up at once at the ports. The rvalid strobe arrives a cycle early or late against the latency the access kind predicts. Or output-enable falls at the wrong edge, which the memory model punishes by returning an inverted byte. A controller that enters the warm path wrongly or misses it is exposed within one access by its 3-cycle or 6-cycle latency and the chip-enable level just after acceptance. A float counter that ends early is seen in the first non-busy cycle. A new output-enable that falls too soon is seen at the edge where it falls.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CEUP,
        ST_ACCESS,
        ST_FLOAT,
        ST_READY
    } rd_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_CLEAR,
        CNT_PRESET,
        CNT_STEP
    } cnt_op_e;

    // ceil(t_ns / per_ns), never below one cycle
    function automatic int ns_to_cycles(int t_ns, int per_ns);
        int c;
        c = (t_ns + per_ns - 1) / per_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_i(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int min_i(int a, int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_cnt.sv
module eprom_rd_cnt
    import eprom_rd_pkg::*;
#(
    parameter int W      = 3,
    parameter int PRESET = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_op_e      op_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (op_i)
            CNT_CLEAR:  cnt_d = '0;
            CNT_PRESET: cnt_d = W'(PRESET);
            CNT_STEP:   cnt_d = cnt_q + W'(1);
            default:    cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = cap_i;
        if (cap_i) cap_d.data = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rdata_o  = cap_q.data;
    assign rvalid_o = cap_q.valid;

    // R5: strobe never lasts two cycles
    assert_rvalid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.valid |=> !cap_q.valid);

    // R5: data register only moves on a strobe
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_q.valid |-> $stable(cap_q.data) || $past(cap_i));

endmodule

// File: rtl/eprom_rd_fsm.sv
module eprom_rd_fsm
    import eprom_rd_pkg::*;
#(
    parameter int AW       = 19,
    parameter int CNT_W    = 3,
    parameter int LAT_CYC  = 5,
    parameter int OE_START = 2,
    parameter int DF_CYC   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output cnt_op_e          cnt_op_o,
    output logic             cap_o,
    output logic             busy_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic             ce_n_o,
    output logic             oe_n_o
);

    typedef struct packed {
        rd_state_e     st;
        logic          ce_n;
        logic          oe_n;
        logic [AW-1:0] addr;
    } fsm_t;

    localparam logic             OE_ENTRY_N = (OE_START != 0) ? 1'b1 : 1'b0;
    localparam logic [CNT_W-1:0] LAST_ACC   = CNT_W'(LAT_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_DF    = CNT_W'(DF_CYC - 1);

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        cnt_op_o = CNT_HOLD;
        cap_o    = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                nxt_d.ce_n = 1'b1;
                nxt_d.oe_n = 1'b1;
                if (req_i) begin
                    nxt_d.st   = ST_ACCESS;
                    nxt_d.addr = addr_i;
                    nxt_d.ce_n = 1'b0;
                    nxt_d.oe_n = OE_ENTRY_N;
                    cnt_op_o   = CNT_CLEAR;
                end
            end
            ST_CEUP: begin
                nxt_d.st   = ST_ACCESS;
                nxt_d.ce_n = 1'b0;
                nxt_d.oe_n = OE_ENTRY_N;
                cnt_op_o   = CNT_CLEAR;
            end
            ST_ACCESS: begin
                if (cnt_i == LAST_ACC) begin
                    cap_o      = 1'b1;
                    nxt_d.st   = ST_FLOAT;
                    nxt_d.oe_n = 1'b1;
                    cnt_op_o   = CNT_CLEAR;
                end else begin
                    nxt_d.oe_n = !((int'(cnt_i) + 1) >= OE_START);
                    cnt_op_o   = CNT_STEP;
                end
            end
            ST_FLOAT: begin
                if (cnt_i == LAST_DF) nxt_d.st = ST_READY;
                else                  cnt_op_o = CNT_STEP;
            end
            ST_READY: begin
                if (req_i && (addr_i == cur_q.addr)) begin
                    nxt_d.st   = ST_ACCESS;
                    nxt_d.oe_n = 1'b0;
                    cnt_op_o   = CNT_PRESET;
                end else if (req_i) begin
                    nxt_d.st   = ST_CEUP;
                    nxt_d.addr = addr_i;
                    nxt_d.ce_n = 1'b1;
                end else begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.ce_n = 1'b1;
                end
            end
            default: begin
                nxt_d.st   = ST_IDLE;
                nxt_d.ce_n = 1'b1;
                nxt_d.oe_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, ce_n: 1'b1, oe_n: 1'b1, addr: '0};
        else        cur_q <= nxt_d;
    end

    assign busy_o     = !((cur_q.st == ST_IDLE) || (cur_q.st == ST_READY));
    assign mem_addr_o = cur_q.addr;
    assign ce_n_o     = cur_q.ce_n;
    assign oe_n_o     = cur_q.oe_n;

    // R1: standby while idle
    assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_IDLE) |-> (cur_q.ce_n && cur_q.oe_n));

    // R3: output-enable only inside chip-enable
    assert_oe_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.oe_n |-> !cur_q.ce_n);

    // R4: address and chip-enable frozen during an access
    assert_stable_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ACCESS && $past(cur_q.st) == ST_ACCESS)
            |-> ($stable(cur_q.addr) && $stable(cur_q.ce_n)));

    // R5: controls released at the capture edge
    assert_release_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> (cur_q.oe_n && cur_q.st == ST_FLOAT));

    // R8: restart cycle holds chip-enable high
    assert_restart_ce_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_CEUP) |-> cur_q.ce_n);

    // R10: busy blocks address updates
    assert_busy_holds_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cur_q.addr));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ADDR_NS     = 90,
    parameter int T_CE_NS       = 90,
    parameter int T_OE_NS       = 50,
    parameter int T_FLOAT_NS    = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_data
);

    localparam int ADDR_CYC = ns_to_cycles(T_ADDR_NS, CLK_PERIOD_NS);
    localparam int CE_CYC   = ns_to_cycles(T_CE_NS, CLK_PERIOD_NS);
    localparam int LAT_CYC  = max_i(ADDR_CYC, CE_CYC);
    localparam int OE_CYC   = min_i(ns_to_cycles(T_OE_NS, CLK_PERIOD_NS), LAT_CYC);
    localparam int OE_START = LAT_CYC - OE_CYC;
    localparam int DF_CYC   = ns_to_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int CNT_MAX  = max_i(LAT_CYC, DF_CYC);
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    cnt_op_e          cnt_op;
    logic [CNT_W-1:0] cnt;
    logic             cap;

    eprom_rd_cnt #(
        .W      (CNT_W),
        .PRESET (OE_START)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (cnt_op),
        .cnt_o (cnt)
    );

    eprom_rd_fsm #(
        .AW       (ADDR_W),
        .CNT_W    (CNT_W),
        .LAT_CYC  (LAT_CYC),
        .OE_START (OE_START),
        .DF_CYC   (DF_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .cnt_i      (cnt),
        .cnt_op_o   (cnt_op),
        .cap_o      (cap),
        .busy_o     (busy),
        .mem_addr_o (mem_addr),
        .ce_n_o     (mem_ce_n),
        .oe_n_o     (mem_oe_n)
    );

    eprom_rd_capture #(
        .DW (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .data_i   (mem_data),
        .rdata_o  (rdata),
        .rvalid_o (rvalid)
    );

endmodule

// File: tb/eprom_rd_ctrl_tb.sv
module eprom_rd_ctrl_tb;

    localparam int PER = 20;

    function automatic int cdiv(int t);
        int c;
        c = (t + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int A_C = cdiv(90);
    localparam int C_C = cdiv(90);
    localparam int O_C = cdiv(50);
    localparam int F_C = cdiv(60);
    localparam int L_C = (A_C > C_C) ? A_C : C_C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [18:0] addr = '0;
    logic        busy, rvalid, mem_ce_n, mem_oe_n;
    logic [7:0]  rdata, mem_data;
    logic [18:0] mem_addr;

    always #10 clk = ~clk;

    eprom_rd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
        .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_data(mem_data)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b01101};
    endfunction

    // memory model: correct byte only once every delay has elapsed
    int addr_age = 0, ce_age = 0, oe_age = 0, oe_hi_age = 0;
    int last_oe_len = 0, since_cap = 0, cyc = 0;
    bit seen_rise = 0, track = 0;
    logic [18:0] prev_addr = '0;
    logic prev_ce_n = 1'b1, prev_oe_n = 1'b1;

    assign mem_data = (!mem_ce_n && !mem_oe_n && addr_age + 1 >= A_C &&
                       ce_age + 1 >= C_C && oe_age + 1 >= O_C)
                      ? pat(mem_addr) : ~pat(mem_addr);

    typedef struct {
        logic [18:0] a;
        int          lat;
        int          c0;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic [18:0] last_a = '0;

    // monitor: timing model, float rule, scoreboard
    always @(negedge clk) begin
        cyc++;
        if (mem_addr !== prev_addr) addr_age = 0; else addr_age++;
        if (mem_ce_n || prev_ce_n) ce_age = 0; else ce_age++;
        if (prev_oe_n && !mem_oe_n) begin
            if (seen_rise) chk(oe_hi_age + 1 >= F_C, "R6 oe refall", oe_hi_age + 1, F_C);
            oe_age = 0;
        end else if (!mem_oe_n) oe_age++;
        if (!prev_oe_n && mem_oe_n) begin
            last_oe_len = oe_age + 1;
            oe_hi_age   = 0;
            seen_rise   = 1;
        end else if (mem_oe_n) oe_hi_age++;

        if (rst_n && rvalid) begin
            if (sb_q.size() == 0) chk(0, "R10 unexpected rvalid", 1, 0);
            else begin
                item_t it;
                it = sb_q.pop_front();
                chk(rdata == pat(it.a), {it.tag, " data"}, int'(rdata), int'(pat(it.a)));
                chk(cyc - it.c0 - 1 == it.lat, {it.tag, " latency"}, cyc - it.c0 - 1, it.lat);
                chk(mem_oe_n == 1'b1, "R5 oe released", int'(mem_oe_n), 1);
                chk(last_oe_len == O_C, "R3 oe window", last_oe_len, O_C);
            end
            since_cap = 0;
            track = 1;
        end else if (track) begin
            since_cap++;
            chk(rvalid == 1'b0, "R5 single pulse", int'(rvalid), 0);
            if (since_cap < F_C) chk(busy == 1'b1, "R6 busy in float", int'(busy), 1);
            else begin
                chk(busy == 1'b0, "R6 busy drop", int'(busy), 0);
                track = 0;
            end
        end
        prev_addr = mem_addr;
        prev_ce_n = mem_ce_n;
        prev_oe_n = mem_oe_n;
    end

    // driver: waits for not-busy, classifies the access, queues expectation
    task automatic issue(logic [18:0] a);
        item_t it;
        forever begin
            @(negedge clk); #1;
            if (!busy) break;
        end
        it.a  = a;
        it.c0 = cyc;
        if (mem_ce_n) begin
            it.lat = L_C;       it.tag = "R2 cold";
        end else if (a == last_a) begin
            it.lat = O_C;       it.tag = "R7 warm";
        end else begin
            it.lat = L_C + 1;   it.tag = "R8 restart";
        end
        sb_q.push_back(it);
        req  = 1'b1;
        addr = a;
        @(negedge clk); #1;
        req  = 1'b0;
        if (it.tag == "R7 warm") chk(mem_ce_n == 1'b0, "R7 ce kept low", int'(mem_ce_n), 0);
        if (it.tag == "R8 restart") begin
            chk(mem_ce_n == 1'b1, "R8 ce high", int'(mem_ce_n), 1);
            chk(mem_addr == a, "R8 new addr", int'(mem_addr), int'(a));
        end
        if (it.tag == "R2 cold") chk(mem_ce_n == 1'b0 && mem_addr == a, "R4 ce and addr", int'(mem_addr), int'(a));
        last_a = a;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (F_C + 4) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(mem_ce_n && mem_oe_n, "R1 reset ce/oe", int'({mem_ce_n, mem_oe_n}), 3);
        chk(!busy && !rvalid, "R1 reset busy/rvalid", int'({busy, rvalid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(19'h12345);
        drain();
        chk(mem_ce_n && mem_oe_n && !busy, "R1 idle standby", int'({mem_ce_n, mem_oe_n, busy}), 6);

        // back-to-back chain: cold, warm, warm, restart, restart
        issue(19'h0ABCD);
        issue(19'h0ABCD);
        issue(19'h0ABCD);
        issue(19'h00001);
        issue(19'h7FFFF);
        while (sb_q.size() != 0) @(negedge clk);
        // wait for the non-busy cycle, then one more edge without request
        forever begin
            @(negedge clk); #1;
            if (!busy) break;
        end
        chk(mem_ce_n == 1'b0, "R9 ready cycle ce low", int'(mem_ce_n), 0);
        @(negedge clk); #1;
        chk(mem_ce_n == 1'b1, "R9 standby after ready", int'(mem_ce_n), 1);

        // requests during busy are dropped
        issue(19'h00000);
        req  = 1'b1;
        addr = 19'h55555;
        repeat (3) @(negedge clk);
        #1;
        chk(mem_addr == 19'h00000, "R10 addr held", int'(mem_addr), 0);
        chk(busy == 1'b1, "R10 still busy", int'(busy), 1);
        req = 1'b0;
        drain();

        // cold access after standby at the top address
        issue(19'h7FFFF);
        drain();
        chk(sb_q.size() == 0, "R10 queue empty", sb_q.size(), 0);
        finish_run();
    end

endmodule